// File: doc/BRIEF.md
# Masked Packed Word-Narrowing Converter

This block is one registered stage of a SIMD datapath. It narrows up to sixteen 32-bit source lanes to 8-bit lanes. It offers three conversion modes: plain truncation, clamping to the signed byte range, and clamping to the unsigned byte range. The narrowed bytes are packed from the least-significant byte of a 128-bit result. A per-lane write mask decides which lanes take the converted value. Each masked-off lane either keeps the byte it already held or is cleared.

The surrounding pipeline provides the conversion opcode, the vector-length select, the mask, the merge/zero choice, the prior destination contents and a flag that says whether the destination is a register or memory. For a register target, every byte above the used width is cleared and no store enables are raised. For a memory target, the block always merges. It raises a per-byte store enable only for the bytes that were actually converted. A malformed encoding raises a fault flag and suppresses all store enables. Inputs are taken on a valid strobe, and everything appears together one clock later.

Top module: `narrow_conv_stage`

## Requirements
- R1: The opcode selects the mode: 8'h31 truncates, 8'h21 applies signed saturation and 8'h11 applies unsigned saturation. Any other opcode is treated as a truncation for the data path and raises the fault flag (see R10).
- R2: A vector-length select of 0 enables 4 lanes, 1 enables 8 lanes, and 2 or 3 enables 16 lanes. Lane j reads source bits [32j+31:32j] and drives result bits [8j+7:8j].
- R3: In truncation mode, a converted lane outputs the low 8 bits of its source word, whatever its sign or size.
- R4: In signed mode, a source word above 127 gives 8'h7F and one below -128 gives 8'h80. Any other word passes its low byte through.
- R5: In unsigned mode, a source word above 255 (read as unsigned) gives 8'hFF. Any other word passes its low byte through.
- R6: An enabled lane is converted when the mask-enable input is low or when its mask bit is set.
- R7: For a register destination, an enabled lane that is not converted gives 8'h00 when the zero flag is set, and otherwise gives its prior destination byte.
- R8: For a register destination, every result byte at or above the enabled lane count is 8'h00, and all 16 store enables are 0.
- R9: For a memory destination, store enable j is 1 only for a converted enabled lane. Every other result byte carries its prior destination byte, and the zero flag has no effect.
- R10: The fault flag is raised when the 4-bit reserved field is not 4'b1111 or the opcode is not one of the three in R1. While the fault flag is raised, all store enables are 0.
- R11: Result, store enables and fault appear with the output valid one clock after an input valid. They hold their values while no input valid arrives. A synchronous active-low reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input capture strobe |
| src_vec | input | 512 | Sixteen 32-bit source lanes |
| vlen_sel | input | 2 | Vector-length select (0: 4 lanes, 1: 8 lanes, 2/3: 16 lanes) |
| opcode | input | 8 | Conversion mode opcode |
| lane_mask | input | 16 | Per-lane write mask |
| mask_en | input | 1 | Mask enable; when low, all enabled lanes convert |
| zero_mode | input | 1 | Clear (1) or keep (0) masked-off lanes of a register target |
| dest_prior | input | 128 | Prior destination contents |
| dest_is_mem | input | 1 | Destination is memory (1) or register (0) |
| rsv_field | input | 4 | Reserved specifier field, must be 4'b1111 |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| result | output | 128 | Packed narrowed result |
| byte_we | output | 16 | Per-byte store enables for a memory target |
| bad_enc | output | 1 | Invalid-encoding fault |

## Verification
All three results (packed bytes, store enables and the fault flag) leave one register stage. They are due on the first rising edge after the edge that saw in_valid high, and they rise together with out_valid. The bench changes the inputs on a falling edge and samples the outputs on the next falling edge, after that single register has loaded. It then checks the outputs against a model that it evaluates from the inputs it saved. For the hold check, the bench leaves in_valid low and applies new inputs for one cycle, then samples again on the next falling edge to confirm that nothing moved.

// File: rtl/narrow_pkg.sv
package narrow_pkg;

   typedef enum logic [1:0] {
      NM_TRUNC = 2'd0,
      NM_SSAT  = 2'd1,
      NM_USAT  = 2'd2,
      NM_NONE  = 2'd3
   } narrow_mode_e;

   localparam logic [7:0] OPC_TRUNC = 8'h31;
   localparam logic [7:0] OPC_SSAT  = 8'h21;
   localparam logic [7:0] OPC_USAT  = 8'h11;
   localparam logic [3:0] RSV_OK    = 4'b1111;

   function automatic narrow_mode_e opc_to_mode(input logic [7:0] opc);
      narrow_mode_e m;
      case (opc)
         OPC_TRUNC: m = NM_TRUNC;
         OPC_SSAT:  m = NM_SSAT;
         OPC_USAT:  m = NM_USAT;
         default:   m = NM_NONE;
      endcase
      return m;
   endfunction

   // smallest vector-length step at which lane j becomes active
   function automatic int lane_need_step(input int j, input int min_lanes, input int steps);
      int s;
      s = steps - 1;
      for (int k = steps - 1; k >= 0; k--) begin
         if (j < (min_lanes << k)) s = k;
      end
      return s;
   endfunction

endpackage

// File: rtl/narrow_mode_dec.sv
module narrow_mode_dec
   import narrow_pkg::*;
(
   input  logic [7:0]   opcode,
   input  logic [3:0]   rsv_field,
   output narrow_mode_e mode,
   output logic         fault
);

   narrow_mode_e raw_mode;

   always_comb begin
      raw_mode = opc_to_mode(opcode);
      // an unknown opcode still steers the data path as a truncation
      mode     = (raw_mode == NM_NONE) ? NM_TRUNC : raw_mode;
      fault    = (rsv_field != RSV_OK) || (raw_mode == NM_NONE);
   end

endmodule

// File: rtl/narrow_lane.sv
module narrow_lane
   import narrow_pkg::*;
#(
   parameter int IN_W  = 32,
   parameter int OUT_W = 8
)(
   input  logic [IN_W-1:0]  src,
   input  narrow_mode_e     mode,
   output logic [OUT_W-1:0] dst
);

   localparam int HEAD_W = IN_W - OUT_W + 1;
   localparam logic [OUT_W-1:0] S_MAX = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] S_MIN = {1'b1, {(OUT_W-1){1'b0}}};
   localparam logic [OUT_W-1:0] U_MAX = {OUT_W{1'b1}};

   generate
      if (OUT_W < 2 || IN_W <= OUT_W) begin : g_bad_w
         $error("narrow_lane: need 2 <= OUT_W < IN_W");
      end
   endgenerate

   logic [HEAD_W-1:0] head;
   logic              s_fits;
   logic              u_fits;

   assign head   = src[IN_W-1:OUT_W-1];
   assign s_fits = (head == '0) || (head == '1);
   assign u_fits = (src[IN_W-1:OUT_W] == '0);

   always_comb begin
      case (mode)
         NM_SSAT: dst = s_fits ? src[OUT_W-1:0] : (src[IN_W-1] ? S_MIN : S_MAX);
         NM_USAT: dst = u_fits ? src[OUT_W-1:0] : U_MAX;
         default: dst = src[OUT_W-1:0];
      endcase
   end

   // signed clamping never flips the sign of the lane
   always_comb begin
      if (mode == NM_SSAT) begin
         p_ssat_sign_r4: assert (dst[OUT_W-1] == src[IN_W-1])
            else $error("signed narrowing changed sign");
      end
   end

   // unsigned result below all-ones means the source fitted and passed through
   always_comb begin
      if (mode == NM_USAT && dst != U_MAX) begin
         p_usat_pass_r5: assert (u_fits && dst == src[OUT_W-1:0])
            else $error("unsigned narrowing mismatch");
      end
   end

endmodule

// File: rtl/narrow_pack.sv
module narrow_pack
   import narrow_pkg::*;
#(
   parameter int LANES = 16,
   parameter int IN_W  = 32,
   parameter int OUT_W = 8
)(
   input  logic [LANES*IN_W-1:0]  src,
   input  narrow_mode_e           mode,
   input  logic [LANES-1:0]       lane_act,
   input  logic [LANES-1:0]       lane_mask,
   input  logic                   mask_en,
   input  logic                   zero_mode,
   input  logic                   is_mem,
   input  logic [LANES*OUT_W-1:0] prior,
   output logic [LANES*OUT_W-1:0] res,
   output logic [LANES-1:0]       we
);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [OUT_W-1:0] cvt;
         logic [OUT_W-1:0] keep;
         logic             take;

         narrow_lane #(
            .IN_W  (IN_W),
            .OUT_W (OUT_W)
         ) u_lane (
            .src  (src[g*IN_W +: IN_W]),
            .mode (mode),
            .dst  (cvt)
         );

         assign keep = prior[g*OUT_W +: OUT_W];
         assign take = lane_act[g] && (!mask_en || lane_mask[g]);

         always_comb begin
            if (take) begin
               res[g*OUT_W +: OUT_W] = cvt;
            end else if (is_mem) begin
               res[g*OUT_W +: OUT_W] = keep;
            end else if (!lane_act[g] || zero_mode) begin
               res[g*OUT_W +: OUT_W] = '0;
            end else begin
               res[g*OUT_W +: OUT_W] = keep;
            end
            we[g] = take && is_mem;
         end

         // a lane outside the active width never asks for a store
         always_comb begin
            if (!lane_act[g]) begin
               p_idle_lane_no_we_r9: assert (!we[g])
                  else $error("inactive lane enabled a store");
            end
         end
      end
   endgenerate

endmodule

// File: rtl/narrow_conv_stage.sv
module narrow_conv_stage
   import narrow_pkg::*;
#(
   parameter  int IN_W      = 32,
   parameter  int OUT_W     = 8,
   parameter  int MIN_LANES = 4,
   parameter  int VL_STEPS  = 3,
   localparam int LANES     = MIN_LANES << (VL_STEPS - 1),
   localparam int VSEL_W    = (VL_STEPS > 1) ? $clog2(VL_STEPS) : 1,
   localparam int SRC_W     = LANES * IN_W,
   localparam int DST_W     = LANES * OUT_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [SRC_W-1:0]  src_vec,
   input  logic [VSEL_W-1:0] vlen_sel,
   input  logic [7:0]        opcode,
   input  logic [LANES-1:0]  lane_mask,
   input  logic              mask_en,
   input  logic              zero_mode,
   input  logic [DST_W-1:0]  dest_prior,
   input  logic              dest_is_mem,
   input  logic [3:0]        rsv_field,
   output logic              out_valid,
   output logic [DST_W-1:0]  result,
   output logic [LANES-1:0]  byte_we,
   output logic              bad_enc
);

   generate
      if (MIN_LANES < 1) begin : g_bad_min
         $error("narrow_conv_stage: MIN_LANES must be at least 1");
      end
      if (VL_STEPS < 1) begin : g_bad_steps
         $error("narrow_conv_stage: VL_STEPS must be at least 1");
      end
   endgenerate

   narrow_mode_e     mode;
   logic             fault;
   logic [LANES-1:0] lane_act;
   logic [DST_W-1:0] res_d;
   logic [LANES-1:0] we_d;

   narrow_mode_dec u_dec (
      .opcode    (opcode),
      .rsv_field (rsv_field),
      .mode      (mode),
      .fault     (fault)
   );

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_act
         localparam int NEED = lane_need_step(j, MIN_LANES, VL_STEPS);
         assign lane_act[j] = (int'(vlen_sel) >= NEED);
      end
   endgenerate

   narrow_pack #(
      .LANES (LANES),
      .IN_W  (IN_W),
      .OUT_W (OUT_W)
   ) u_pack (
      .src       (src_vec),
      .mode      (mode),
      .lane_act  (lane_act),
      .lane_mask (lane_mask),
      .mask_en   (mask_en),
      .zero_mode (zero_mode),
      .is_mem    (dest_is_mem),
      .prior     (dest_prior),
      .res       (res_d),
      .we        (we_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         byte_we   <= '0;
         bad_enc   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result  <= res_d;
            byte_we <= fault ? '0 : we_d;
            bad_enc <= fault;
         end
      end
   end

   p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(byte_we) && $stable(bad_enc)));

   p_reg_no_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !dest_is_mem) |=> (byte_we == '0));

   p_rsv_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && rsv_field != RSV_OK) |=> (bad_enc && byte_we == '0));

   generate
      if (VL_STEPS > 1) begin : g_upper_chk
         p_reg_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !dest_is_mem && vlen_sel == '0)
               |=> (result[DST_W-1:MIN_LANES*OUT_W] == '0));
      end
   endgenerate

endmodule

// File: tb/narrow_conv_stage_bench.sv
module narrow_conv_stage_bench;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [511:0] src_vec;
   logic [1:0]   vlen_sel;
   logic [7:0]   opcode;
   logic [15:0]  lane_mask;
   logic         mask_en;
   logic         zero_mode;
   logic [127:0] dest_prior;
   logic         dest_is_mem;
   logic [3:0]   rsv_field;
   logic         out_valid;
   logic [127:0] result;
   logic [15:0]  byte_we;
   logic         bad_enc;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   narrow_conv_stage u_narrow_conv_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .src_vec     (src_vec),
      .vlen_sel    (vlen_sel),
      .opcode      (opcode),
      .lane_mask   (lane_mask),
      .mask_en     (mask_en),
      .zero_mode   (zero_mode),
      .dest_prior  (dest_prior),
      .dest_is_mem (dest_is_mem),
      .rsv_field   (rsv_field),
      .out_valid   (out_valid),
      .result      (result),
      .byte_we     (byte_we),
      .bad_enc     (bad_enc)
   );

   task automatic check(input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model(input logic [511:0] s, input logic [1:0] vs, input logic [7:0] op,
                        input logic [15:0] m, input logic men, input logic zm,
                        input logic [127:0] pr, input logic mem, input logic [3:0] rv,
                        output logic [127:0] r, output logic [15:0] w, output logic f);
      int  n;
      bit  known;
      n     = (vs == 2'd0) ? 4 : (vs == 2'd1) ? 8 : 16;
      known = (op == 8'h31) || (op == 8'h21) || (op == 8'h11);
      f     = (rv != 4'hF) || !known;
      for (int j = 0; j < 16; j++) begin
         logic [31:0] x;
         logic [7:0]  cv;
         x = s[j*32 +: 32];
         if (op == 8'h21) begin
            if ($signed(x) > 32'sd127)       cv = 8'h7F;
            else if ($signed(x) < -32'sd128) cv = 8'h80;
            else                             cv = x[7:0];
         end else if (op == 8'h11) begin
            cv = (x > 32'd255) ? 8'hFF : x[7:0];
         end else begin
            cv = x[7:0];
         end
         if (j >= n) begin
            r[j*8 +: 8] = mem ? pr[j*8 +: 8] : 8'h00;
            w[j] = 1'b0;
         end else if (!men || m[j]) begin
            r[j*8 +: 8] = cv;
            w[j] = mem;
         end else begin
            r[j*8 +: 8] = (!mem && zm) ? 8'h00 : pr[j*8 +: 8];
            w[j] = 1'b0;
         end
      end
      if (f) w = '0;
   endtask

   // drive current stimulus for one cycle and check one clock later
   task automatic run_op(input string req);
      logic [127:0] er;
      logic [15:0]  ew;
      logic         ef;
      model(src_vec, vlen_sel, opcode, lane_mask, mask_en, zero_mode,
            dest_prior, dest_is_mem, rsv_field, er, ew, ef);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, "out_valid", {127'd0, out_valid}, 128'd1);
      check(req, "result", result, er);
      check(req, "byte_we", {112'd0, byte_we}, {112'd0, ew});
      check(req, "bad_enc", {127'd0, bad_enc}, {127'd0, ef});
   endtask

   task automatic set_defaults();
      vlen_sel    = 2'd2;
      opcode      = 8'h31;
      lane_mask   = 16'hFFFF;
      mask_en     = 1'b0;
      zero_mode   = 1'b0;
      dest_prior  = 128'hA5A5_5A5A_C3C3_3C3C_0F0F_F0F0_1234_ABCD;
      dest_is_mem = 1'b0;
      rsv_field   = 4'hF;
   endtask

   task automatic fill_words(input logic [31:0] a, input logic [31:0] b,
                             input logic [31:0] c, input logic [31:0] d);
      for (int j = 0; j < 16; j++) begin
         case (j % 4)
            0: src_vec[j*32 +: 32] = a;
            1: src_vec[j*32 +: 32] = b;
            2: src_vec[j*32 +: 32] = c;
            default: src_vec[j*32 +: 32] = d;
         endcase
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R11 watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      rst_n    = 1'b0;
      in_valid = 1'b1;
      src_vec  = {16{32'hDEAD_BEEF}};
      set_defaults();
      repeat (3) @(negedge clk);
      // R11: reset clears outputs even with in_valid held high
      check("R11", "reset out_valid", {127'd0, out_valid}, 128'd0);
      check("R11", "reset result", result, 128'd0);
      check("R11", "reset byte_we", {112'd0, byte_we}, 128'd0);
      check("R11", "reset bad_enc", {127'd0, bad_enc}, 128'd0);
      in_valid = 1'b0;
      rst_n    = 1'b1;
      @(negedge clk);

      // R3 truncation, all 16 lanes
      fill_words(32'h1234_5680, 32'hFFFF_FF7F, 32'h8000_0001, 32'h0000_00FF);
      run_op("R3");
      // R4 signed saturation boundaries
      fill_words(32'd127, 32'd128, 32'hFFFF_FF80, 32'hFFFF_FF7F);
      opcode = 8'h21; run_op("R4");
      fill_words(32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFB, 32'd5);
      run_op("R4");
      // R5 unsigned saturation boundaries
      fill_words(32'd255, 32'd256, 32'hFFFF_FFFF, 32'd0);
      opcode = 8'h11; run_op("R5");
      // R1 each opcode on one source
      fill_words(32'h0000_0190, 32'hFFFF_FE00, 32'd77, 32'h0001_0042);
      opcode = 8'h31; run_op("R1");
      opcode = 8'h21; run_op("R1");
      opcode = 8'h11; run_op("R1");
      // R7 register merge and zero
      opcode = 8'h31; mask_en = 1'b1; lane_mask = 16'hA5C3; zero_mode = 1'b0;
      run_op("R7");
      zero_mode = 1'b1; run_op("R7");
      // R6 mask ignored when masking disabled
      mask_en = 1'b0; lane_mask = 16'h0000; run_op("R6");
      // R2 / R8 narrower widths to a register
      vlen_sel = 2'd0; run_op("R8");
      vlen_sel = 2'd1; mask_en = 1'b1; lane_mask = 16'h00F0; zero_mode = 1'b0;
      run_op("R2");
      vlen_sel = 2'd3; run_op("R2");
      // R9 memory target, zero flag has no effect
      dest_is_mem = 1'b1; vlen_sel = 2'd2; zero_mode = 1'b1; lane_mask = 16'h3C69;
      run_op("R9");
      vlen_sel = 2'd0; mask_en = 1'b0; run_op("R9");
      // R10 faults
      vlen_sel = 2'd2; rsv_field = 4'hE; run_op("R10");
      rsv_field = 4'hF; opcode = 8'h41; run_op("R10");
      // R11 hold: change inputs without valid, outputs stay
      begin
         logic [127:0] r_s;
         logic [15:0]  w_s;
         logic         f_s;
         set_defaults(); dest_is_mem = 1'b1;
         fill_words(32'd1, 32'd2, 32'd3, 32'd4);
         run_op("R11");
         r_s = result; w_s = byte_we; f_s = bad_enc;
         fill_words(32'h55, 32'h66, 32'h77, 32'h88);
         dest_is_mem = 1'b0; rsv_field = 4'h0;
         @(negedge clk);
         check("R11", "idle out_valid", {127'd0, out_valid}, 128'd0);
         check("R11", "hold result", result, r_s);
         check("R11", "hold byte_we", {112'd0, byte_we}, {112'd0, w_s});
         check("R11", "hold bad_enc", {127'd0, bad_enc}, {127'd0, f_s});
      end

      // random mix (R1 through R10)
      for (int t = 0; t < 400; t++) begin
         for (int j = 0; j < 16; j++) begin
            case ($urandom_range(0, 3))
               0: src_vec[j*32 +: 32] = $urandom_range(0, 300);
               1: src_vec[j*32 +: 32] = 32'hFFFF_FF00 + $urandom_range(0, 255) - 32'd40;
               default: src_vec[j*32 +: 32] = $urandom;
            endcase
         end
         case ($urandom_range(0, 9))
            0: opcode = 8'($urandom);
            1, 2, 3: opcode = 8'h21;
            4, 5, 6: opcode = 8'h11;
            default: opcode = 8'h31;
         endcase
         vlen_sel    = 2'($urandom);
         lane_mask   = 16'($urandom);
         mask_en     = 1'($urandom);
         zero_mode   = 1'($urandom);
         dest_prior  = {$urandom, $urandom, $urandom, $urandom};
         dest_is_mem = 1'($urandom);
         rsv_field   = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
         run_op("R1");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule